// File: doc/BRIEF.md
# Three-Channel APB Down-Counting Timer Bank

This block places three identical 32-bit down-counters behind one zero-wait-state APB slave port. Software programs a reload value and a control word per channel. Each running channel then counts down by one on every clock. When a channel reaches zero it reloads, either from its programmed value (periodic) or from all ones (free-running), and it raises a pending flag. Each channel drives its own level interrupt output. That output is the pending flag gated by a per-channel mask. A read of the channel's clear register drops the pending flag, as does turning the channel off. The inverse of a free-running channel's live count serves as an up-counting time base.

Each channel is controlled by a two-state machine. STOP is the idle state. In STOP the counter holds its value and no interrupt can become pending. RUN is the counting state. The START transition goes from STOP to RUN when a control write sets the enable bit, and it copies the reload value into the counter. The HALT transition goes from RUN to STOP when a control write clears the enable bit. HALT also clears the pending flag, and the counter keeps the value it had. An EXPIRE event keeps the channel in RUN. It happens on the clock after the counter has held zero: the counter reloads and the pending flag sets.

Top module: `tmr_bank_apb`

## Requirements
- R1: After reset every counter holds 0xFFFFFFFF, every reload and control register reads zero, no flag is pending and all interrupt outputs are low.
- R2: Channel n occupies byte addresses n*0x14 to n*0x14+0x13. The word offsets within a channel are: 0x00 reload value (read/write), 0x04 live count (read only), 0x08 control (read/write), 0x0C interrupt clear (read), 0x10 raw status with bit 0 = pending. In the control word, bit 0 is enable, bit 1 selects periodic (1) or free-running (0), and bit 2 is the interrupt mask. A read-only version word sits at 0xAC. Reads of any other address return zero, and writes to read-only locations are ignored.
- R3: A control write that sets enable on a stopped channel loads the counter from the reload register on that same clock. A control write with enable set on a channel that is already running does not reload it.
- R4: While running, the count drops by exactly one per clock, and the live value is readable. While stopped, the count does not change.
- R5: In periodic mode, a counter that holds zero reloads the reload value on the next clock and sets the pending flag, so a reload value L gives an L+1 clock period.
- R6: In free-running mode the counter reloads 0xFFFFFFFF instead of the reload value.
- R7: Writing the reload register while a channel runs does not change the live count. The new value is used at the next START or periodic reload.
- R8: A read of a channel's interrupt clear register returns zero and clears that channel's pending flag. If an expiry falls on the same clock, the flag stays set.
- R9: Clearing enable stops the counter at its current value and clears the pending flag.
- R10: A channel's interrupt output is high exactly when its flag is pending and its mask bit is clear. The raw status shows the pending flag whatever the mask.
- R11: The slave has zero wait states. Ready is always high, read data is valid during the access phase, and a write takes effect at the clock edge that ends the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| irq | output | 3 | Per-channel level interrupt |

## Verification
A bus access spends one clock in setup and one in access. Read data is sampled half a clock before the access edge, and the write or clear takes effect on that edge. A count read issued right after an enable write therefore shows the reload value minus one. Every further clock between transfers subtracts one more, and an expiry lands L+1 clocks after START. The stimulus table and the directed tests place each read and interrupt sample at a cycle offset derived from these rules. Samples avoid the clocks on which an expiry or a clear would make the result depend on process order.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // word index inside one channel's window
    localparam logic [2:0] RG_LOAD = 3'd0;
    localparam logic [2:0] RG_CUR  = 3'd1;
    localparam logic [2:0] RG_CTRL = 3'd2;
    localparam logic [2:0] RG_CLR  = 3'd3;
    localparam logic [2:0] RG_RAW  = 3'd4;

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_PER  = 1;
    localparam int CB_MASK = 2;

endpackage

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TMR  = 3,
    parameter int ADDR_W   = 8,
    parameter int STRIDE   = 20,
    parameter int VER_ADDR = 172
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TMR-1:0] ch_hit,
    output logic [2:0]         reg_idx,
    output logic               ver_hit
);

    int rel;

    always_comb begin
        ch_hit  = '0;
        reg_idx = RG_LOAD;
        rel     = 0;
        for (int n = 0; n < NUM_TMR; n++) begin
            rel = int'(addr) - n * STRIDE;
            if (rel >= 0 && rel < STRIDE && (rel % 4) == 0) begin
                ch_hit[n] = 1'b1;
                reg_idx   = 3'(rel / 4);
            end
        end
    end

    assign ver_hit = (int'(addr) == VER_ADDR);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic             ctrl_we,
    input  logic             clr_rd,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load_val,
    output logic             en,
    output logic             periodic,
    output logic             mask,
    output logic             pend,
    output logic             irq
);

    ch_state_e state, state_nx;
    logic      start, halt, expire;

    // next-state logic: START and HALT transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_STOP: if (ctrl_we && wdata[CB_EN])  state_nx = CH_RUN;
            CH_RUN:  if (ctrl_we && !wdata[CB_EN]) state_nx = CH_STOP;
            default: state_nx = CH_STOP;
        endcase
    end

    assign start  = (state == CH_STOP) && (state_nx == CH_RUN);
    assign halt   = (state == CH_RUN)  && (state_nx == CH_STOP);
    assign expire = (state == CH_RUN)  && !halt && (count == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_STOP;
        else        state <= state_nx;
    end

    // counter, reload value and control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '1;
            load_val <= '0;
            periodic <= 1'b0;
            mask     <= 1'b0;
        end else begin
            if (load_we) load_val <= wdata;
            if (ctrl_we) begin
                periodic <= wdata[CB_PER];
                mask     <= wdata[CB_MASK];
            end
            if (start)
                count <= load_val;
            else if (expire)
                count <= periodic ? load_val : '1;
            else if (state == CH_RUN && !halt)
                count <= count - CNT_W'(1);
        end
    end

    // pending flag: expiry beats clear, halt beats both
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend <= 1'b0;
        else if (halt)   pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (clr_rd) pend <= 1'b0;
    end

    // outputs
    always_comb begin
        en  = (state == CH_RUN);
        irq = pend && !mask;
    end

endmodule

// File: rtl/tmr_bank_apb.sv
module tmr_bank_apb
    import tmr_pkg::*;
#(
    parameter int          NUM_TMR  = 3,
    parameter int          CNT_W    = 32,
    parameter int          ADDR_W   = 8,
    parameter int          STRIDE   = 20,
    parameter int          VER_ADDR = 172,
    parameter logic [31:0] VERSION  = 32'h0001_0203
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [CNT_W-1:0]   pwdata,
    output logic [CNT_W-1:0]   prdata,
    output logic               pready,
    output logic [NUM_TMR-1:0] irq
);

    logic [NUM_TMR-1:0]            ch_hit;
    logic [2:0]                    reg_idx;
    logic                          ver_hit;
    logic                          acc_wr, acc_rd;
    logic [NUM_TMR-1:0]            ch_en, ch_mode, ch_mask, ch_pend;
    logic [NUM_TMR-1:0][CNT_W-1:0] ch_cnt, ch_load;

    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;
    assign pready = 1'b1;

    tmr_apb_decode #(
        .NUM_TMR (NUM_TMR),
        .ADDR_W  (ADDR_W),
        .STRIDE  (STRIDE),
        .VER_ADDR(VER_ADDR)
    ) i_decode (
        .addr   (paddr),
        .ch_hit (ch_hit),
        .reg_idx(reg_idx),
        .ver_hit(ver_hit)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) i_ch (
            .clk     (pclk),
            .rst_n   (presetn),
            .load_we (acc_wr && ch_hit[n] && reg_idx == RG_LOAD),
            .ctrl_we (acc_wr && ch_hit[n] && reg_idx == RG_CTRL),
            .clr_rd  (acc_rd && ch_hit[n] && reg_idx == RG_CLR),
            .wdata   (pwdata),
            .count   (ch_cnt[n]),
            .load_val(ch_load[n]),
            .en      (ch_en[n]),
            .periodic(ch_mode[n]),
            .mask    (ch_mask[n]),
            .pend    (ch_pend[n]),
            .irq     (irq[n])
        );
    end

    always_comb begin
        prdata = '0;
        if (ver_hit) prdata = CNT_W'(VERSION);
        for (int n = 0; n < NUM_TMR; n++) begin
            if (ch_hit[n]) begin
                case (reg_idx)
                    RG_LOAD: prdata = ch_load[n];
                    RG_CUR:  prdata = ch_cnt[n];
                    RG_CTRL: prdata = CNT_W'({ch_mask[n], ch_mode[n], ch_en[n]});
                    RG_RAW:  prdata = CNT_W'(ch_pend[n]);
                    default: prdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32
) (
    input logic                          pclk,
    input logic                          presetn,
    input logic                          pready,
    input logic [NUM_TMR-1:0]            irq,
    input logic [NUM_TMR-1:0]            ch_en,
    input logic [NUM_TMR-1:0]            ch_mode,
    input logic [NUM_TMR-1:0]            ch_mask,
    input logic [NUM_TMR-1:0]            ch_pend,
    input logic [NUM_TMR-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_TMR-1:0][CNT_W-1:0] ch_load
);

    assert_ready_R11: assert property (@(posedge pclk) disable iff (!presetn)
        pready);

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_chk
        assert_mask_gates_irq_R10: assert property (@(posedge pclk) disable iff (!presetn)
            irq[n] == (ch_pend[n] && !ch_mask[n]));

        assert_pend_from_expiry_R5: assert property (@(posedge pclk) disable iff (!presetn)
            $rose(ch_pend[n]) |-> $past(ch_en[n] && ch_cnt[n] == '0));

        assert_decrement_R4: assert property (@(posedge pclk) disable iff (!presetn)
            (ch_en[n] && $past(ch_en[n]) && $past(ch_cnt[n]) != '0)
                |-> ch_cnt[n] == $past(ch_cnt[n]) - CNT_W'(1));

        assert_hold_when_off_R4: assert property (@(posedge pclk) disable iff (!presetn)
            (!ch_en[n] && $past(!ch_en[n])) |-> $stable(ch_cnt[n]));

        assert_periodic_reload_R5: assert property (@(posedge pclk) disable iff (!presetn)
            (ch_en[n] && $past(ch_en[n] && ch_mode[n] && ch_cnt[n] == '0))
                |-> ch_cnt[n] == $past(ch_load[n]));

        assert_free_reload_R6: assert property (@(posedge pclk) disable iff (!presetn)
            (ch_en[n] && $past(ch_en[n] && !ch_mode[n] && ch_cnt[n] == '0))
                |-> ch_cnt[n] == '1);

        assert_off_no_pend_R9: assert property (@(posedge pclk) disable iff (!presetn)
            !ch_en[n] |-> !ch_pend[n]);
    end

endmodule

bind tmr_bank_apb tmr_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) i_chk (
    .pclk   (pclk),
    .presetn(presetn),
    .pready (pready),
    .irq    (irq),
    .ch_en  (ch_en),
    .ch_mode(ch_mode),
    .ch_mask(ch_mask),
    .ch_pend(ch_pend),
    .ch_cnt (ch_cnt),
    .ch_load(ch_load)
);

// File: tb/test_tmr_bank_apb.sv
module test_tmr_bank_apb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VER = 32'h0001_0203;

    // vector: {op, req, addr, data, expected}
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_D = 2'd2, OP_I = 2'd3;
    localparam int NVEC = 42;
    localparam logic [77:0] VEC [NVEC] = '{
        {OP_R, 4'd2,  8'hAC, 32'h0,  VER},           // R2 version
        {OP_R, 4'd1,  8'h04, 32'h0,  32'hFFFF_FFFF}, // R1 reset count
        {OP_R, 4'd1,  8'h08, 32'h0,  32'h0},         // R1 reset ctrl
        {OP_W, 4'd2,  8'h00, 32'd10, 32'h0},
        {OP_R, 4'd2,  8'h00, 32'h0,  32'd10},        // R2 reload readback
        {OP_R, 4'd4,  8'h04, 32'h0,  32'hFFFF_FFFF}, // R4 stopped holds
        {OP_W, 4'd3,  8'h08, 32'd3,  32'h0},         // START periodic
        {OP_R, 4'd3,  8'h04, 32'h0,  32'd9},         // R3 loaded then -1
        {OP_R, 4'd4,  8'h04, 32'h0,  32'd7},         // R4
        {OP_R, 4'd2,  8'h08, 32'h0,  32'd3},
        {OP_D, 4'd0,  8'h00, 32'd8,  32'h0},
        {OP_R, 4'd5,  8'h10, 32'h0,  32'd1},         // R5 pending
        {OP_I, 4'd10, 8'h00, 32'h0,  32'd1},         // R10
        {OP_R, 4'd8,  8'h0C, 32'h0,  32'h0},         // R8 clear read
        {OP_R, 4'd8,  8'h10, 32'h0,  32'h0},         // R8
        {OP_I, 4'd8,  8'h00, 32'h0,  32'h0},
        {OP_D, 4'd0,  8'h00, 32'd1,  32'h0},
        {OP_W, 4'd9,  8'h08, 32'd0,  32'h0},         // HALT
        {OP_I, 4'd9,  8'h00, 32'h0,  32'h0},         // R9 pending cleared
        {OP_R, 4'd5,  8'h04, 32'h0,  32'd10},        // R5 reloaded value
        {OP_R, 4'd9,  8'h04, 32'h0,  32'd10},        // R9 held
        {OP_W, 4'd2,  8'h14, 32'd5,  32'h0},
        {OP_W, 4'd6,  8'h1C, 32'd1,  32'h0},         // channel 1 free-running
        {OP_D, 4'd0,  8'h00, 32'd5,  32'h0},
        {OP_R, 4'd6,  8'h18, 32'h0,  32'hFFFF_FFFF}, // R6 all-ones reload
        {OP_I, 4'd10, 8'h00, 32'h0,  32'd2},
        {OP_W, 4'd10, 8'h1C, 32'd5,  32'h0},         // set mask
        {OP_I, 4'd10, 8'h00, 32'h0,  32'd0},         // R10 masked
        {OP_R, 4'd10, 8'h24, 32'h0,  32'd1},         // R10 raw unmasked
        {OP_R, 4'd2,  8'h1C, 32'h0,  32'd5},
        {OP_R, 4'd3,  8'h18, 32'h0,  32'hFFFF_FFF7}, // R3 no reload on re-enable
        {OP_R, 4'd8,  8'h20, 32'h0,  32'h0},
        {OP_R, 4'd8,  8'h24, 32'h0,  32'h0},
        {OP_W, 4'd2,  8'h28, 32'd2,  32'h0},
        {OP_W, 4'd5,  8'h30, 32'd3,  32'h0},         // channel 2 periodic
        {OP_D, 4'd0,  8'h00, 32'd3,  32'h0},
        {OP_R, 4'd5,  8'h38, 32'h0,  32'd1},         // R5 period L+1
        {OP_I, 4'd10, 8'h00, 32'h0,  32'd4},
        {OP_R, 4'd2,  8'h40, 32'h0,  32'h0},         // R2 unmapped
        {OP_R, 4'd2,  8'h3C, 32'h0,  32'h0},         // R2 just past last channel
        {OP_W, 4'd2,  8'hAC, 32'h1234, 32'h0},
        {OP_R, 4'd2,  8'hAC, 32'h0,  VER}            // R2 version unwritable
    };

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [2:0]  irq;
    int          n_vec = 0, n_bad = 0;
    logic [31:0] rd, rd2;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    tmr_bank_apb i_tmr_bank_apb (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        r = prdata;
        @(posedge pclk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        check("R1 irq after reset", {29'b0, irq}, 32'h0);
        presetn = 1'b1;
        check("R11 ready", {31'b0, pready}, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, rq, a, d, e} = VEC[i];
            case (op)
                OP_W: xfer(1'b1, a, d, rd);
                OP_R: begin
                    xfer(1'b0, a, 32'h0, rd);
                    check($sformatf("R%0d vec %0d", rq, i), rd, e);
                end
                OP_D: repeat (d) @(posedge pclk);
                default: check($sformatf("R%0d irq vec %0d", rq, i), {29'b0, irq}, e);
            endcase
        end

        // R7: reload write while channel 2 runs leaves the count alone
        xfer(1'b1, 8'h28, 32'd100, rd);
        xfer(1'b0, 8'h2C, 32'h0, rd);
        check("R7 count unchanged by reload write", {31'b0, (rd <= 32'd2)}, 32'h1);
        // R9: halt holds the count
        xfer(1'b1, 8'h30, 32'd0, rd);
        check("R9 irq after halt", {29'b0, irq}, 32'h0);
        xfer(1'b0, 8'h2C, 32'h0, rd);
        xfer(1'b0, 8'h2C, 32'h0, rd2);
        check("R9 count held", rd2, rd);
        // R3/R7: restart uses new reload value
        xfer(1'b1, 8'h30, 32'd3, rd);
        xfer(1'b0, 8'h2C, 32'h0, rd);
        check("R7 new reload used at start", rd, 32'd99);
        xfer(1'b1, 8'h30, 32'd3, rd);
        xfer(1'b0, 8'h2C, 32'h0, rd);
        check("R3 enable while running keeps counting", rd, 32'd95);

        // R1: reset mid-run
        @(negedge pclk);
        presetn = 1'b0;
        repeat (2) @(negedge pclk);
        check("R1 irq during reset", {29'b0, irq}, 32'h0);
        presetn = 1'b1;
        xfer(1'b0, 8'h2C, 32'h0, rd);
        check("R1 count after reset", rd, 32'hFFFF_FFFF);
        xfer(1'b0, 8'h30, 32'h0, rd);
        check("R1 ctrl after reset", rd, 32'h0);
        xfer(1'b0, 8'h28, 32'h0, rd);
        check("R1 reload after reset", rd, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule